// File: doc/BRIEF.md
# Burst Initiator with Latency Timer

This block is the requesting side of a multiplexed address/data bus. The user side gives it a one-cycle start pulse together with a target address, a command code, a byte-lane mask, a burst length and a latency-timer value. The block then asks the arbiter for the bus, waits for the grant, and drives an address phase. It follows this with as many data phases as the target accepts. For writes the block drives the user's write data onto the bus. For reads it returns each word that arrives, flagged with a one-cycle valid strobe. All bus control lines are active low.

A down-counting latency timer is loaded when the address phase begins. If the arbiter takes the grant away and the timer has run out, the block closes the burst early: the phase in progress becomes the final one. The target can cut a burst short with its halt line. If no target claims the cycle within five data clocks, the block abandons the cycle as a master abort. At the end of every burst a one-cycle done strobe reports an end code and the number of phases that actually moved.

Top module: `burst_initiator`

## Requirements
- R1: After reset, the request, frame and initiator-ready lines are high (inactive), the bus output enable is low, and done is low.
- R2: A start pulse in the idle state drives the request line low on the next clock. The frame line stays high until the grant line has been seen low on a clock edge, and falls on the following clock.
- R3: In the first cycle with frame low (the address phase), the bus carries the address, the lane lines carry the command, and the output enable is high.
- R4: In every data phase the lane lines carry the byte mask. Command bit 0 set means write: the bus then carries wr_data_i, which the user holds at the word for phase index phase_cnt_o. Command bit 0 clear means read: the output enable is low.
- R5: A data phase completes on a clock edge where initiator-ready and target-ready are both low. While target-ready is high, initiator-ready stays low and the phase count stays put.
- R6: Frame goes high in the cycle that presents the final data phase, while initiator-ready is low. Initiator-ready goes high after that phase completes.
- R7: The latency timer loads lat_cfg_i at the address phase and decrements once per clock. In a data cycle where it reads zero and the grant line is high, frame rises on the next clock. A burst that ends this way with fewer phases than requested reports end code 2.
- R8: While the grant line stays low, an expired timer has no effect, and the full length transfers with end code 0.
- R9: The target halt line low on a clock edge ends the burst. The phase in that cycle counts if target-ready was also low. The end code is 1.
- R10: If the select line has not been low by the fifth data clock after the address phase, the burst ends as a master abort with end code 3 and a count of 0. Done is high in the sixth cycle after the address phase.
- R11: Done is a one-cycle pulse in the cycle after the final completion. In that cycle status_o gives the end code and phase_cnt_o gives the phases moved. A burst whose full length moves reports code 0.
- R12: On each completed read phase, rd_vld_o pulses for one cycle in the next cycle, with rd_data_o holding the word that was on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a burst |
| addr_i | input | DW | Burst start address |
| cmd_i | input | LANES | Command code, bit 0 set for write |
| be_i | input | LANES | Byte-lane mask for data phases |
| len_i | input | LW | Requested number of data phases (0 treated as 1) |
| lat_cfg_i | input | TW | Latency timer reload value |
| wr_data_i | input | DW | Write word for the current phase index |
| rd_data_o | output | DW | Last read word |
| rd_vld_o | output | 1 | Read word strobe |
| phase_cnt_o | output | LW | Phases completed in this burst |
| done_o | output | 1 | End-of-burst strobe |
| status_o | output | 2 | End code: 0 full, 1 halted, 2 timer, 3 no claim |
| arb_req_n | output | 1 | Bus request, active low |
| arb_gnt_n | input | 1 | Bus grant, active low |
| cyc_n | output | 1 | Frame line, active low |
| init_rdy_n | output | 1 | Initiator ready, active low |
| tgt_rdy_n | input | 1 | Target ready, active low |
| tgt_sel_n | input | 1 | Target claim, active low |
| tgt_halt_n | input | 1 | Target halt request, active low |
| mux_o | output | DW | Address/data bus, driven side |
| mux_oe | output | 1 | Bus output enable |
| mux_i | input | DW | Address/data bus, received side |
| lane_o | output | LANES | Command / byte-lane lines |

## Verification
The interesting coincidence is the latency timer running out in the same cycle that a data phase completes or the target raises its halt line. The bench removes the grant right after the address phase and pairs small timer values with target wait patterns of zero to two idle clocks. It also places halt requests on both ready and non-ready cycles. This makes expiry, the natural last phase and the halt land on the same edge. A bench model predicts the phase count and end code from the timer value, the wait spacing and the halt position, and compares them at the done pulse. It also checks the frame level at every completed phase against the predicted final index.

// File: rtl/burst_init_pkg.sv
package burst_init_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ASK  = 3'd1,
        S_ADDR = 3'd2,
        S_XFER = 3'd3,
        S_END  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        E_FULL    = 2'd0,
        E_HALTED  = 2'd1,
        E_EXPIRED = 2'd2,
        E_NOCLAIM = 2'd3
    } end_e;

endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    input  logic [TW-1:0] val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: one step down per running clock
    a_r7_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/claim_watch.sv
module claim_watch #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic sel_n_i,
    output logic miss_o
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          claimed;
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (clr_i) begin
            w_d.cnt     = '0;
            w_d.claimed = 1'b0;
        end else if (run_i) begin
            if (!sel_n_i) w_d.claimed = 1'b1;
            if (w_q.cnt != CW'(LIMIT)) w_d.cnt = w_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign miss_o = run_i && !w_q.claimed && sel_n_i && (w_q.cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
    import burst_init_pkg::*;
#(
    parameter int DW          = 32,
    parameter int LANES       = DW / 8,
    parameter int LW          = 8,
    parameter int TW          = 8,
    parameter int CLAIM_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DW-1:0]    addr_i,
    input  logic [LANES-1:0] cmd_i,
    input  logic [LANES-1:0] be_i,
    input  logic [LW-1:0]    len_i,
    input  logic [TW-1:0]    lat_cfg_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_vld_o,
    output logic [LW-1:0]    phase_cnt_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic             arb_req_n,
    input  logic             arb_gnt_n,
    output logic             cyc_n,
    output logic             init_rdy_n,
    input  logic             tgt_rdy_n,
    input  logic             tgt_sel_n,
    input  logic             tgt_halt_n,
    output logic [DW-1:0]    mux_o,
    output logic             mux_oe,
    input  logic [DW-1:0]    mux_i,
    output logic [LANES-1:0] lane_o
);

    typedef struct packed {
        phase_e           st;
        logic [DW-1:0]    addr;
        logic [LANES-1:0] cmd;
        logic [LANES-1:0] be;
        logic [LW-1:0]    len;
        logic [LW-1:0]    cnt;
        logic             req_n;
        logic             frame_n;
        logic             irdy_n;
        logic [DW-1:0]    rdata;
        logic             rvld;
        logic             done;
        end_e             status;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st: S_IDLE, addr: '0, cmd: '0, be: '0, len: '0, cnt: '0,
        req_n: 1'b1, frame_n: 1'b1, irdy_n: 1'b1,
        rdata: '0, rvld: 1'b0, done: 1'b0, status: E_FULL
    };

    regs_t r_d, r_q;

    logic          xfer, take, finish, load_tmr, tmr_expired, miss;
    logic [LW-1:0] cnt_inc;

    lat_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_tmr),
        .run_i     ((r_q.st == S_ADDR) || (r_q.st == S_XFER)),
        .val_i     (lat_cfg_i),
        .expired_o (tmr_expired)
    );

    claim_watch #(.LIMIT(CLAIM_LIMIT)) u_claim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (load_tmr),
        .run_i   (r_q.st == S_XFER),
        .sel_n_i (tgt_sel_n),
        .miss_o  (miss)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rvld = 1'b0;
        r_d.done = 1'b0;
        xfer     = (r_q.st == S_XFER) && !r_q.irdy_n && !tgt_rdy_n;
        cnt_inc  = r_q.cnt + LW'(1);
        take     = 1'b0;
        finish   = 1'b0;
        load_tmr = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st    = S_ASK;
                    r_d.addr  = addr_i;
                    r_d.cmd   = cmd_i;
                    r_d.be    = be_i;
                    r_d.len   = (len_i == '0) ? LW'(1) : len_i;
                    r_d.cnt   = '0;
                    r_d.req_n = 1'b0;
                end
            end
            S_ASK: begin
                if (!arb_gnt_n) begin
                    r_d.st      = S_ADDR;
                    r_d.frame_n = 1'b0;
                    load_tmr    = 1'b1;
                end
            end
            S_ADDR: begin
                r_d.st     = S_XFER;
                r_d.irdy_n = 1'b0;
                if (r_q.len == LW'(1)) r_d.frame_n = 1'b1;
            end
            S_XFER: begin
                take = xfer && !miss;
                if (miss) begin
                    finish     = 1'b1;
                    r_d.status = E_NOCLAIM;
                end else if (!tgt_halt_n) begin
                    finish     = 1'b1;
                    r_d.status = E_HALTED;
                end else if (xfer && r_q.frame_n) begin
                    finish     = 1'b1;
                    r_d.status = (cnt_inc == r_q.len) ? E_FULL : E_EXPIRED;
                end else if (!r_q.frame_n &&
                             ((xfer && cnt_inc == r_q.len - LW'(1)) ||
                              (tmr_expired && arb_gnt_n))) begin
                    r_d.frame_n = 1'b1;
                end
            end
            S_END: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
        if (take) begin
            r_d.cnt = cnt_inc;
            if (!r_q.cmd[0]) begin
                r_d.rdata = mux_i;
                r_d.rvld  = 1'b1;
            end
        end
        if (finish) begin
            r_d.st      = S_END;
            r_d.frame_n = 1'b1;
            r_d.irdy_n  = 1'b1;
            r_d.req_n   = 1'b1;
            r_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign arb_req_n   = r_q.req_n;
    assign cyc_n       = r_q.frame_n;
    assign init_rdy_n  = r_q.irdy_n;
    assign mux_o       = (r_q.st == S_ADDR) ? r_q.addr : wr_data_i;
    assign mux_oe      = (r_q.st == S_ADDR) || ((r_q.st == S_XFER) && r_q.cmd[0]);
    assign lane_o      = (r_q.st == S_ADDR) ? r_q.cmd : r_q.be;
    assign rd_data_o   = r_q.rdata;
    assign rd_vld_o    = r_q.rvld;
    assign phase_cnt_o = r_q.cnt;
    assign done_o      = r_q.done;
    assign status_o    = r_q.status;

    // R2: frame only falls after a sampled grant
    a_r2_frame_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_n) |-> $past(!arb_gnt_n));

    // R6: outside an abort or halt, frame rises only while initiator-ready is low
    a_r6_frame_rise_under_irdy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_n) && !done_o) |-> !init_rdy_n);

    // R5: a wait cycle keeps initiator-ready low and the count unchanged
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_XFER) && tgt_rdy_n && tgt_halt_n && !miss)
            |=> (!init_rdy_n && $stable(phase_cnt_o)));

    // R9: a halt request ends the burst on the next clock
    a_r9_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == S_XFER) && !tgt_halt_n) |=> done_o);

    // R10: a master abort reports no moved phases
    a_r10_abort_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd3) |-> (phase_cnt_o == '0));

    // R11: done is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_burst_initiator.sv
`timescale 1ns/1ps
module sim_burst_initiator;

    localparam int DW = 32;
    localparam int LN = 4;
    localparam int LW = 8;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] addr_i = '0;
    logic [LN-1:0] cmd_i = '0;
    logic [LN-1:0] be_i = '0;
    logic [LW-1:0] len_i = '0;
    logic [TW-1:0] lat_cfg_i = '0;
    logic [DW-1:0] wr_data_i;
    logic [DW-1:0] rd_data_o;
    logic          rd_vld_o;
    logic [LW-1:0] phase_cnt_o;
    logic          done_o;
    logic [1:0]    status_o;
    logic          arb_req_n;
    logic          arb_gnt_n = 1'b1;
    logic          cyc_n;
    logic          init_rdy_n;
    logic          tgt_rdy_n = 1'b1;
    logic          tgt_sel_n = 1'b1;
    logic          tgt_halt_n = 1'b1;
    logic [DW-1:0] mux_o;
    logic          mux_oe;
    logic [DW-1:0] mux_i = '0;
    logic [LN-1:0] lane_o;

    int nchk = 0;
    int nfail = 0;

    // scenario context shared with the target model
    int      w_g = 0, stop_g = 0, gd_g = 0, expn_g = 0;
    bit      claim_g = 1'b1, drop_g = 1'b0, chkf_g = 1'b0;
    logic [DW-1:0] addr_g = '0;
    logic [LN-1:0] cmd_g = '0, be_g = '0;
    bit      txn = 1'b0, seen_addr = 1'b0, done_seen = 1'b0;
    int      k = 0, since = 0, gw = 0, tj = 0, rj = 0, done_at = 0;
    logic [1:0] st_at_done = '0;
    logic [LW-1:0] cnt_at_done = '0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] wpat(input logic [LW-1:0] j);
        return 32'h5A00_0000 ^ ({24'd0, j} * 32'h0101_0101) ^ 32'h0000_0F0F;
    endfunction

    function automatic logic [DW-1:0] rpat(input logic [DW-1:0] a, input int kk);
        return a ^ (kk * 32'h0001_0001) ^ 32'hC3C3_0000;
    endfunction

    assign wr_data_i = wpat(phase_cnt_o);

    burst_initiator #(.DW(DW), .LANES(LN), .LW(LW), .TW(TW), .CLAIM_LIMIT(5)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .cmd_i(cmd_i),
        .be_i(be_i), .len_i(len_i), .lat_cfg_i(lat_cfg_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .phase_cnt_o(phase_cnt_o),
        .done_o(done_o), .status_o(status_o), .arb_req_n(arb_req_n), .arb_gnt_n(arb_gnt_n),
        .cyc_n(cyc_n), .init_rdy_n(init_rdy_n), .tgt_rdy_n(tgt_rdy_n), .tgt_sel_n(tgt_sel_n),
        .tgt_halt_n(tgt_halt_n), .mux_o(mux_o), .mux_oe(mux_oe), .mux_i(mux_i), .lane_o(lane_o)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // target, arbiter and monitor model, all acting on the falling edge
    always @(negedge clk) begin
        bit act, trdy_v;
        if (rst_n) begin
            if (!txn && !cyc_n) begin
                txn = 1'b1; k = 0; since = 0; seen_addr = 1'b1;
                check(gw > gd_g, "R2 address after grant", gw, gd_g + 1);
                check(mux_o == addr_g && mux_oe, "R3 address on bus", {mux_oe, mux_o}, {1'b1, addr_g});
                check(lane_o == cmd_g, "R3 command on lanes", lane_o, cmd_g);
            end else begin
                if (txn) begin
                    if (cyc_n && init_rdy_n) txn = 1'b0;
                    else k++;
                end
                since++;
            end
            if (done_o && !done_seen) begin
                done_seen = 1'b1; done_at = since;
                st_at_done = status_o; cnt_at_done = phase_cnt_o;
            end
            arb_gnt_n <= !(!arb_req_n && gw >= gd_g && !(drop_g && seen_addr));
            if (!arb_req_n && !seen_addr) gw++;
            act    = txn && k >= 1 && claim_g;
            trdy_v = act && (k % (w_g + 1) == 0);
            tgt_sel_n  <= !act;
            tgt_rdy_n  <= !trdy_v;
            tgt_halt_n <= !(act && stop_g != 0 && k == stop_g);
            mux_i      <= rpat(addr_g, k);
            if (txn && !init_rdy_n && trdy_v) begin
                check(lane_o == be_g, "R4 byte mask in data phase", lane_o, be_g);
                if (cmd_g[0]) begin
                    check(mux_oe && mux_o == wpat(LW'(tj)), "R4 write word", mux_o, wpat(LW'(tj)));
                end else begin
                    check(!mux_oe, "R4 read leaves bus undriven", mux_oe, 0);
                end
                if (chkf_g) begin
                    check(cyc_n == (tj == expn_g - 1), "R6 frame level at phase", cyc_n, (tj == expn_g - 1));
                end
                tj++;
            end
            if (rd_vld_o) begin
                check(rd_data_o == rpat(addr_g, (w_g + 1) * (rj + 1)), "R12 read word",
                      rd_data_o, rpat(addr_g, (w_g + 1) * (rj + 1)));
                rj++;
            end
        end
    end

    task automatic do_run(input logic [DW-1:0] a, input logic [LN-1:0] c, input logic [LN-1:0] be,
                          input int len, input int lat, input int w, input int stp, input int gd,
                          input bit cl, input bit dr);
        int n, endk, stat, donek, f, nt, guard;
        if (!cl) begin
            n = 0; stat = 3; donek = 6;
        end else begin
            n = len;
            if (dr) begin
                f  = ((lat > 1) ? lat : 1) + 1;
                nt = (f + w) / (w + 1);
                if (nt < n) n = nt;
            end
            endk = (w + 1) * n;
            if (stp > 0 && stp <= endk) begin
                n = stp / (w + 1); stat = 1; endk = stp;
            end else begin
                stat = (n == len) ? 0 : 2;
            end
            donek = endk + 1;
        end
        @(negedge clk);
        w_g = w; stop_g = stp; gd_g = gd; claim_g = cl; drop_g = dr;
        addr_g = a; cmd_g = c; be_g = be; expn_g = n; chkf_g = cl && (stat != 1);
        seen_addr = 1'b0; done_seen = 1'b0; gw = 0; tj = 0; rj = 0;
        start_i = 1'b1; addr_i = a; cmd_i = c; be_i = be;
        len_i = LW'(len); lat_cfg_i = TW'(lat);
        @(negedge clk);
        start_i = 1'b0;
        check(!arb_req_n, "R2 request after start", arb_req_n, 0);
        guard = 0;
        while (!done_seen && guard < 600) begin
            @(negedge clk); #1;
            guard++;
        end
        check(done_seen, "R11 done seen", done_seen, 1);
        check(st_at_done == 2'(stat), "R11 end code (R7 R9 R10)", st_at_done, stat);
        check(cnt_at_done == LW'(n), "R11 phase count (R7 R8 R9)", cnt_at_done, n);
        check(done_at == donek, "R11 done timing (R10)", done_at, donek);
        check(tj == n, "R5 completed phases seen", tj, n);
        check(rj == (c[0] ? 0 : n), "R12 read strobes", rj, (c[0] ? 0 : n));
        @(negedge clk);
        check(!done_o, "R11 done is one pulse", done_o, 0);
        check(init_rdy_n && cyc_n, "R6 lines released", {init_rdy_n, cyc_n}, 2'b11);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(arb_req_n && cyc_n && init_rdy_n && !mux_oe && !done_o, "R1 reset state",
              {arb_req_n, cyc_n, init_rdy_n, mux_oe, done_o}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        do_run(32'h1000_0040, 4'b0111, 4'hF, 4, 20, 0, 0, 0, 1, 0); // R11 full write
        do_run(32'h2000_0100, 4'b0110, 4'h3, 5, 20, 1, 0, 0, 1, 0); // R12 R5 read with waits
        do_run(32'h3000_0000, 4'b0011, 4'hC, 2, 20, 0, 0, 3, 1, 0); // R2 grant delay
        do_run(32'h4000_0000, 4'b0111, 4'hF, 8, 2, 0, 0, 0, 1, 1);  // R7 timer cut
        do_run(32'h4100_0000, 4'b0110, 4'hF, 4, 0, 1, 0, 0, 1, 1);  // R7 zero timer
        do_run(32'h5000_0000, 4'b0111, 4'hF, 6, 0, 0, 0, 0, 1, 0);  // R8 grant held
        do_run(32'h6000_0000, 4'b0111, 4'hF, 8, 20, 0, 3, 0, 1, 0); // R9 halt with data
        do_run(32'h6100_0000, 4'b0110, 4'hF, 8, 20, 1, 3, 0, 1, 0); // R9 halt on wait
        do_run(32'h7000_0000, 4'b0111, 4'hF, 4, 20, 0, 0, 0, 0, 0); // R10 master abort
        do_run(32'h8000_0000, 4'b0110, 4'h1, 1, 20, 2, 0, 1, 1, 0); // R6 single phase
        do_run(32'h9000_0000, 4'b0111, 4'hF, 6, 3, 2, 6, 0, 1, 1);  // R7 R9 same edge
        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [DW-1:0] ra;
            int rlen, rlat, rw, rst, rgd;
            bit rcl, rdr;
            ra   = $urandom;
            rlen = 1 + ($urandom % 8);
            rlat = $urandom % 13;
            rw   = $urandom % 3;
            rst  = (($urandom % 4) == 0) ? 1 + ($urandom % 12) : 0;
            rgd  = $urandom % 4;
            rcl  = (($urandom % 10) != 0);
            rdr  = $urandom % 2;
            do_run(ra, {3'b011, 1'($urandom % 2)}, 4'($urandom), rlen, rlat, rw, rst, rgd, rcl, rdr);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule